// File: doc/BRIEF.md
# Commit-to-Coprocessor Decoupling Queue

This block sits between the commit point of a main processor and a tag-tracking coprocessor. Each committed instruction is handed over as a tuple holding its program counter, its encoding and its physical memory address. The tuple waits in a small in-order FIFO until the coprocessor can take it. Because of the FIFO the core and the coprocessor can run at different rates for short stretches. Ordinary instructions leave the core without waiting. The core sees back-pressure only when the FIFO is full.

Some instructions are synchronisation points: system calls, traps, memory fences and any instruction carrying an external interrupt. Such an instruction is held at the core until three things are true: the FIFO is empty, the coprocessor reports that its pipeline holds no tuple, and no security exception is outstanding. The coprocessor reports a failed tag check with a one-cycle pulse. The block latches that pulse and holds it as a level to the core until the core acknowledges it. In this way a synchronisation point can never commit past an exception that has not been delivered.

Both tuple interfaces use valid/ready. On the input side, a tuple is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is combinational and may depend on `out_ready` in the same cycle. The core may hold a tuple while it is not accepted, and the block does not require the tuple to stay stable. On the output side, `out_valid` comes from storage, does not depend on `out_ready`, and holds with a stable tuple until the coprocessor accepts it. Setting the depth parameter to zero removes the storage and turns the block into a combinational pass-through with the same synchronisation rules.

Top module: `commit_decouple_queue`

## Requirements
- R1: After reset the queue is empty (`out_valid` low), the exception level `exc_to_core` is low, and an ordinary tuple is ready to be accepted.
- R2: Tuples leave in the order they were accepted, with PC, encoding and address unchanged. `out_valid` is high exactly when at least one tuple is stored. A presented tuple stays stable until it is accepted.
- R3: With DEPTH tuples stored and `out_ready` low, no tuple is accepted. The queue never holds more than DEPTH tuples.
- R4: An ordinary instruction (`in_kind` = 0, `in_irq` = 0) is accepted whenever fewer than DEPTH tuples are stored, whatever the state of the coprocessor or of the exception.
- R5: With the queue full, an ordinary tuple is accepted in the same cycle in which `out_ready` dequeues one, and the occupancy stays at DEPTH.
- R6: A system call (`in_kind` = 1), trap (`in_kind` = 2) or fence (`in_kind` = 3) is accepted only when the queue is empty and `cop_idle` is high.
- R7: An instruction presented with `in_irq` high is synchronised like a trap, whatever its `in_kind`.
- R8: A `cop_exc` pulse sets `exc_to_core` in the next cycle. It stays set until a cycle with `exc_ack` high and `cop_exc` low, and it clears in the cycle after that. A new pulse wins over an acknowledge in the same cycle.
- R9: No synchronising instruction is accepted while `exc_to_core` is high or `cop_exc` is high.
- R10: With DEPTH = 0, `out_valid` equals `in_valid` gated by the synchronisation rule, `in_ready` equals `out_ready` gated by the same rule, and the tuple passes through in the same cycle.
- R11: `core_stall` is high exactly when `in_valid` is high and the tuple is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Core presents a committed tuple |
| in_ready | output | 1 | Tuple accepted this cycle when high with in_valid |
| in_kind | input | 2 | 0 ordinary, 1 system call, 2 trap, 3 fence |
| in_irq | input | 1 | External interrupt attached to this instruction |
| in_pc | input | 32 | Program counter |
| in_insn | input | 32 | Instruction encoding |
| in_maddr | input | 32 | Physical memory address for loads and stores |
| core_stall | output | 1 | Core must hold its commit this cycle |
| out_valid | output | 1 | Tuple offered to the coprocessor |
| out_ready | input | 1 | Coprocessor takes the tuple |
| out_pc | output | 32 | Program counter of the head tuple |
| out_insn | output | 32 | Encoding of the head tuple |
| out_maddr | output | 32 | Address of the head tuple |
| cop_idle | input | 1 | Coprocessor pipeline holds no tuple |
| cop_exc | input | 1 | One-cycle pulse for a failed tag check |
| exc_to_core | output | 1 | Latched security exception to the core |
| exc_ack | input | 1 | Core acknowledges the exception |

## Verification
`in_ready` and `core_stall` are combinational, so they are due in the same cycle as the inputs that drive them. The same holds for every output of the zero-depth instance. A tuple accepted at a rising edge is offered on `out_valid` from the following cycle. `exc_to_core` changes one edge after `cop_exc` or an acknowledge. The bench drives inputs at the falling edge and samples one nanosecond later, before the next rising edge. Its occupancy, order and exception model is advanced only after that sample, so each result is compared against the state the requirements fix for that exact cycle.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  parameter int unsigned PC_W   = 32;
  parameter int unsigned INSN_W = 32;
  parameter int unsigned MA_W   = 32;

  typedef enum logic [1:0] {
    KIND_PLAIN   = 2'd0,
    KIND_SYSCALL = 2'd1,
    KIND_TRAP    = 2'd2,
    KIND_FENCE   = 2'd3
  } commit_kind_e;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [INSN_W-1:0] insn;
    logic [MA_W-1:0]   maddr;
  } commit_tuple_t;

  function automatic logic needs_drain(input commit_kind_e k, input logic irq);
    return (k != KIND_PLAIN) || irq;
  endfunction
endpackage

// File: rtl/cdq_fifo.sv
module cdq_fifo #(
  parameter int unsigned DEPTH = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  output logic                   push_ready,
  input  cdq_pkg::commit_tuple_t push_data,
  output logic                   pop_valid,
  input  logic                   pop_ready,
  output cdq_pkg::commit_tuple_t pop_data,
  output logic                   empty
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign push_ready = pop_ready;
      assign pop_valid  = push_valid;
      assign pop_data   = push_data;
      assign empty      = 1'b1;
    end else begin : g_store
      localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      localparam int unsigned CW = $clog2(DEPTH + 1);
      localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
      localparam logic [CW-1:0] FULLC = CW'(DEPTH);

      cdq_pkg::commit_tuple_t slots [DEPTH];
      logic [AW-1:0] wr_ptr, rd_ptr;
      logic [CW-1:0] fill;
      logic          full_q, do_push, do_pop;

      function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
      endfunction

      assign full_q     = (fill == FULLC);
      assign empty      = (fill == '0);
      assign push_ready = !full_q || pop_ready;
      assign pop_valid  = !empty;
      assign pop_data   = slots[rd_ptr];
      assign do_push    = push_valid && push_ready;
      assign do_pop     = pop_ready && !empty;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          fill   <= '0;
        end else begin
          if (do_push) wr_ptr <= bump(wr_ptr);
          if (do_pop)  rd_ptr <= bump(rd_ptr);
          case ({do_push, do_pop})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_data;
      end
    end
  endgenerate
endmodule

// File: rtl/cdq_sync_gate.sv
module cdq_sync_gate (
  input  logic       in_valid,
  input  logic [1:0] in_kind,
  input  logic       in_irq,
  input  logic       q_empty,
  input  logic       q_push_ready,
  input  logic       cop_idle,
  input  logic       exc_pend,
  input  logic       cop_exc,
  output logic       q_push_valid,
  output logic       in_ready,
  output logic       core_stall
);
  import cdq_pkg::*;

  logic drain_req;
  logic drained;
  logic admit;

  assign drain_req = needs_drain(commit_kind_e'(in_kind), in_irq);
  // A synchronising tuple waits for an empty queue, an idle consumer and
  // no undelivered exception (latched or arriving this cycle).
  assign drained   = q_empty && cop_idle && !exc_pend && !cop_exc;
  assign admit     = !drain_req || drained;

  assign q_push_valid = in_valid && admit;
  assign in_ready     = admit && q_push_ready;
  assign core_stall   = in_valid && !in_ready;
endmodule

// File: rtl/cdq_exc_latch.sv
module cdq_exc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cop_exc,
  input  logic exc_ack,
  output logic exc_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)       exc_pend <= 1'b0;
    else if (cop_exc) exc_pend <= 1'b1;
    else if (exc_ack) exc_pend <= 1'b0;
  end
endmodule

// File: rtl/commit_decouple_queue.sv
module commit_decouple_queue #(
  parameter int unsigned DEPTH = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_kind,
  input  logic                      in_irq,
  input  logic [cdq_pkg::PC_W-1:0]   in_pc,
  input  logic [cdq_pkg::INSN_W-1:0] in_insn,
  input  logic [cdq_pkg::MA_W-1:0]   in_maddr,
  output logic                      core_stall,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [cdq_pkg::PC_W-1:0]   out_pc,
  output logic [cdq_pkg::INSN_W-1:0] out_insn,
  output logic [cdq_pkg::MA_W-1:0]   out_maddr,
  input  logic                      cop_idle,
  input  logic                      cop_exc,
  output logic                      exc_to_core,
  input  logic                      exc_ack
);
  import cdq_pkg::*;

  commit_tuple_t in_tup, out_tup;
  logic q_push_valid, q_push_ready, q_empty, exc_pend;

  assign in_tup.pc    = in_pc;
  assign in_tup.insn  = in_insn;
  assign in_tup.maddr = in_maddr;

  cdq_exc_latch u_exc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cop_exc  (cop_exc),
    .exc_ack  (exc_ack),
    .exc_pend (exc_pend)
  );

  cdq_sync_gate u_gate (
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_irq       (in_irq),
    .q_empty      (q_empty),
    .q_push_ready (q_push_ready),
    .cop_idle     (cop_idle),
    .exc_pend     (exc_pend),
    .cop_exc      (cop_exc),
    .q_push_valid (q_push_valid),
    .in_ready     (in_ready),
    .core_stall   (core_stall)
  );

  cdq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (q_push_valid),
    .push_ready (q_push_ready),
    .push_data  (in_tup),
    .pop_valid  (out_valid),
    .pop_ready  (out_ready),
    .pop_data   (out_tup),
    .empty      (q_empty)
  );

  assign out_pc      = out_tup.pc;
  assign out_insn    = out_tup.insn;
  assign out_maddr   = out_tup.maddr;
  assign exc_to_core = exc_pend;
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
  parameter int unsigned DEPTH = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [1:0]                in_kind,
  input logic                      in_irq,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [cdq_pkg::PC_W-1:0]   out_pc,
  input logic                      cop_idle,
  input logic                      cop_exc,
  input logic                      exc_to_core,
  input logic                      exc_ack
);
  int occ;
  logic push, pop, syncy;

  assign push  = in_valid && in_ready;
  assign pop   = out_valid && out_ready;
  assign syncy = (in_kind != 2'd0) || in_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= 0;
    else        occ <= occ + (push ? 1 : 0) - (pop ? 1 : 0);
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= int'(DEPTH));

  assert_plain_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !syncy && occ < int'(DEPTH)) |-> in_ready);

  assert_sync_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && syncy) |-> (occ == 0 && cop_idle));

  assert_sync_no_exc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && syncy) |-> (!exc_to_core && !cop_exc));

  assert_exc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cop_exc |=> exc_to_core);

  assert_exc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_to_core && !exc_ack) |=> exc_to_core);

  assert_head_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && DEPTH > 0) |=> (out_valid && $stable(out_pc)));
endmodule

bind commit_decouple_queue cdq_checker #(.DEPTH(DEPTH)) u_cdq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_kind     (in_kind),
  .in_irq      (in_irq),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_pc      (out_pc),
  .cop_idle    (cop_idle),
  .cop_exc     (cop_exc),
  .exc_to_core (exc_to_core),
  .exc_ack     (exc_ack)
);

// File: tb/tb_commit_decouple_queue.sv
module tb_commit_decouple_queue;
  localparam int D = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        v = 0, irq = 0, ordy = 0, idle = 1, exc = 0, ack = 0;
  logic [1:0]  kind = 0;
  logic [31:0] pc_in = 0, insn_in, ma_in;
  assign insn_in = pc_in ^ 32'h5A5A_0F0F;
  assign ma_in   = ~pc_in;

  logic        rdy, stall, ov, ev;
  logic [31:0] opc, oin, oma;
  logic        rdy0, stall0, ov0, ev0;
  logic [31:0] opc0, oin0, oma0;

  commit_decouple_queue #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_ready(rdy), .in_kind(kind),
    .in_irq(irq), .in_pc(pc_in), .in_insn(insn_in), .in_maddr(ma_in),
    .core_stall(stall), .out_valid(ov), .out_ready(ordy), .out_pc(opc),
    .out_insn(oin), .out_maddr(oma), .cop_idle(idle), .cop_exc(exc),
    .exc_to_core(ev), .exc_ack(ack));

  commit_decouple_queue #(.DEPTH(0)) dut0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_ready(rdy0), .in_kind(kind),
    .in_irq(irq), .in_pc(pc_in), .in_insn(insn_in), .in_maddr(ma_in),
    .core_stall(stall0), .out_valid(ov0), .out_ready(ordy), .out_pc(opc0),
    .out_insn(oin0), .out_maddr(oma0), .cop_idle(idle), .cop_exc(exc),
    .exc_to_core(ev0), .exc_ack(ack));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] q [0:7];
  int head = 0, mcnt = 0;
  logic mexc = 0;
  logic [31:0] npc = 32'h0000_1000;
  logic [31:0] rng = 32'hC0FF_EE11;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input logic tv, input logic [1:0] tk, input logic ti,
                      input logic to, input logic tid, input logic te, input logic ta);
    logic is_s, gate, er, g0;
    string tag;
    @(negedge clk);
    v = tv; kind = tk; irq = ti; ordy = to; idle = tid; exc = te; ack = ta; pc_in = npc;
    #1;
    is_s = (tk != 2'd0) || ti;
    gate = !is_s || (mcnt == 0 && tid && !mexc && !te);
    er   = gate && (mcnt < D || to);
    if (!is_s) tag = (mcnt < D) ? "R4" : (to ? "R5" : "R3");
    else if (mexc || te) tag = "R9";
    else if (ti) tag = "R7";
    else tag = "R6";
    chk(rdy == er, tag, 32'(rdy), 32'(er));
    chk(stall == (tv && !er), "R11", 32'(stall), 32'(tv && !er));
    chk(ov == (mcnt > 0), "R2", 32'(ov), 32'(mcnt > 0));
    if (mcnt > 0) begin
      chk(opc == q[head], "R2", opc, q[head]);
      chk(oin == (q[head] ^ 32'h5A5A_0F0F) && oma == ~q[head], "R2", oin, q[head] ^ 32'h5A5A_0F0F);
    end
    chk(ev == mexc, "R8", 32'(ev), 32'(mexc));
    g0 = !is_s || (tid && !mexc && !te);
    chk(rdy0 == (g0 && to), "R10", 32'(rdy0), 32'(g0 && to));
    chk(ov0 == (tv && g0), "R10", 32'(ov0), 32'(tv && g0));
    if (tv) chk(opc0 == npc && oma0 == ~npc, "R10", opc0, npc);
    if (mcnt > 0 && to) begin head = (head + 1) % 8; mcnt--; end
    if (tv && er) begin q[(head + mcnt) % 8] = npc; mcnt++; npc = npc + 32'd4; end
    if (te) mexc = 1; else if (ta) mexc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(ov == 0 && ev == 0, "R1", {30'd0, ov, ev}, 32'd0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(rdy == 1 && ov == 0 && ev == 0, "R1", {29'd0, rdy, ov, ev}, 32'd4);
    // R3 fill to capacity with consumer stalled, then R5 push+pop when full
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, 0, 0);
    // R6 system call held while queue non-empty and consumer busy
    for (int i = 0; i < 8; i++) step(1, 1, 0, 1, 0, 0, 0);
    step(1, 1, 0, 1, 1, 0, 0);
    step(1, 3, 0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 1, 0, 0);
    // R7 interrupt on an ordinary instruction
    step(1, 0, 1, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    step(1, 0, 1, 1, 1, 0, 0);
    // R8/R9 exception pulse, sync blocked, ack releases
    step(0, 0, 0, 1, 1, 0, 0);
    step(1, 2, 0, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 2, 0, 1, 1, 0, 0);
    step(1, 2, 0, 1, 1, 1, 1);
    step(1, 2, 0, 1, 1, 0, 1);
    step(1, 2, 0, 1, 1, 0, 0);
    step(1, 0, 0, 1, 1, 0, 0);
    // near-exhaustive sweep of input combinations
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      r = rng;
      step(r[0] | r[9], r[2:1] & {2{r[3] & r[10]}}, r[4] & r[11] & r[12],
           r[5] | (i[8] & r[13]), r[6] | r[14], r[7] & r[15] & r[16], r[8]);
    end
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, 0, 1);
    summary();
  end
endmodule